// File: doc/BRIEF.md
# Match Event Timer

This block is a 32-bit up-counting timer that raises an interrupt when its count reaches a value loaded by software. The counter runs on the main bus clock and moves forward only in cycles where a slow tick-enable input is high. That input carries the sleep-clock rate into the bus clock domain as a one-cycle strobe. Software reaches the block through four word registers on a simple memory-mapped bus with single-cycle writes and combinational reads.

A one-shot event is armed in three steps: zero the count through the clear register, load the match value, then set the run bit. When the tick that brings the count to the match value arrives, the interrupt line rises and stays high. Software acknowledges the event by writing zero to the control register. This also stops the count. A second control bit can make the counter return to zero on the matching tick instead of running past it.

Top module: `evt_match_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the match value, count and control bits are all set to zero and irq_out goes low. After reset, every register reads 0.
- R2: Word registers are selected by bus_addr[3:2]: 0 = match value (read/write), 1 = count, 2 = control, 3 = clear. A write takes effect at the edge that ends a cycle with bus_sel and bus_wr high. bus_rdata shows the selected register in the same cycle. An address that is not word-aligned, or that lies outside the 16-byte window, writes nothing and reads 0.
- R3: While control bit 0 (run) is 1, the count goes up by one after each cycle in which tick_en is high. While run is 0, the count holds.
- R4: While control bit 1 (clear-on-match) is 1, the tick that would bring the count to the match value loads 0 into the count instead.
- R5: Writing the clear register with data bit 0 set makes the count 0 at the next edge. This takes priority over a tick in the same cycle. Writing 0 there leaves the count alone, and the clear register always reads 0.
- R6: irq_out rises at the edge that ends a cycle in which run is 1, tick_en is high and the count plus one equals the match value. The smallest supported match value is 0xF, and it behaves the same way.
- R7: A control write with data bit 0 clear takes irq_out low at the next edge, even when a match tick falls in the same cycle. From that edge on, counting stops.
- R8: Without clear-on-match, the count keeps increasing past the match value. irq_out stays high with a single rising edge until it is acknowledged.
- R9: Writes to the count register are ignored, and the count register reads back the live counter. Control bits [31:2] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Sleep-clock tick strobe, one bus cycle per tick |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Level interrupt, high from the match until acknowledged |

## Verification
Read data is combinational, so the register a read selects shows its value during the access cycle itself. A write or a tick shows up in a read one cycle later, because the count and control registers update at the closing edge. irq_out also changes at the edge that ends the matching tick cycle, or the acknowledging write cycle. Stimulus is applied just after a rising edge, and every expected value is queued along with the access. The monitor compares the outputs at the following falling edge, so each check sees the state left by the previous edge and nothing else.

// File: rtl/evt_timer_pkg.sv
// Shared definitions for the match event timer: register word indices
// and control bit positions. Assumes a 16-byte register window.
package evt_timer_pkg;

    // Word index taken from bus_addr[3:2]
    typedef enum logic [1:0] {
        WORD_MATCH = 2'd0,
        WORD_COUNT = 2'd1,
        WORD_CTRL  = 2'd2,
        WORD_CLEAR = 2'd3
    } word_sel_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_COM_BIT = 1;
    localparam int WINDOW_BITS  = 4;

endpackage

// File: rtl/evt_timer_regs.sv
// Register file of the match event timer. Decodes the bus, holds the
// match value and control bits, produces the clear and disarm strobes,
// and muxes read data. Assumes single-cycle accesses and ADDR_W >= 4.
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] match_val,
    output logic              run,
    output logic              clr_on_match,
    output logic              clr_pulse,
    output logic              disarm
);

    localparam int CTRL_W = 2;

    logic              hi_zero;
    logic              addr_ok;
    logic              wr_hit;
    logic              rd_hit;
    word_sel_e         word;
    logic [DATA_W-1:0] match_q;
    logic [CTRL_W-1:0] ctrl_q;

    // Upper address bits must be zero for the window to be selected
    generate
        if (ADDR_W > WINDOW_BITS) begin : g_hi_dec
            assign hi_zero = ~|bus_addr[ADDR_W-1:WINDOW_BITS];
        end else begin : g_no_hi
            assign hi_zero = 1'b1;
        end
    endgenerate

    // Address qualification and access strobes
    always_comb begin
        addr_ok = hi_zero && (bus_addr[1:0] == 2'b00);
        word    = word_sel_e'(bus_addr[3:2]);
        wr_hit  = bus_sel && bus_wr && addr_ok;
        rd_hit  = bus_sel && !bus_wr && addr_ok;
    end

    // Match value and control bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_hit) begin
            if (word == WORD_MATCH) match_q <= bus_wdata;
            if (word == WORD_CTRL)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        end
    end

    // Write-triggered strobes toward the counter and interrupt stages
    always_comb begin
        clr_pulse = wr_hit && (word == WORD_CLEAR) && bus_wdata[0];
        disarm    = wr_hit && (word == WORD_CTRL) && !bus_wdata[CTRL_RUN_BIT];
    end

    // Read data mux, zero for unselected or rejected accesses
    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            case (word)
                WORD_MATCH: bus_rdata = match_q;
                WORD_COUNT: bus_rdata = cnt_val;
                WORD_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign match_val    = match_q;
    assign run          = ctrl_q[CTRL_RUN_BIT];
    assign clr_on_match = ctrl_q[CTRL_COM_BIT];

    // R2: a match write is visible from the next cycle
    a_r2_match_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && word == WORD_MATCH) |=> (match_val == $past(bus_wdata)));

    // R9: upper control bits never appear on a control read
    a_r9_ctrl_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && word == WORD_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));

    // R7: a disarm write leaves run low
    a_r7_run_off: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !run);

endmodule

// File: rtl/evt_timer_counter.sv
// Tick-gated up counter with match compare. Counts when run and tick_en
// are both high. Clear has priority over counting, and clear-on-match
// reloads zero on the matching tick. Produces the one-cycle hit strobe.
module evt_timer_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run,
    input  logic              clr_on_match,
    input  logic              clr_pulse,
    input  logic [DATA_W-1:0] match_val,
    output logic [DATA_W-1:0] cnt,
    output logic              hit
);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_inc;
    logic              adv;
    logic              eq_next;

    // Next-value and compare terms
    always_comb begin
        cnt_inc = cnt_q + DATA_W'(1);
        adv     = run && tick_en;
        eq_next = (cnt_inc == match_val);
        hit     = adv && eq_next;
    end

    // Counter register: clear beats advance, match reload when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_pulse) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (clr_on_match && eq_next) ? '0 : cnt_inc;
        end
    end

    assign cnt = cnt_q;

    // R3: stopped counter holds its value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_pulse) |=> $stable(cnt));

    // R3: each enabled tick adds one unless cleared or reloaded
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !clr_pulse && !(clr_on_match && hit))
        |=> (cnt == $past(cnt) + DATA_W'(1)));

    // R4: matching tick with clear-on-match leaves zero
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_on_match && !clr_pulse) |=> (cnt == '0));

    // R5: clear strobe zeroes the count
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (cnt == '0));

endmodule

// File: rtl/evt_timer_irq.sv
// Interrupt latch. Sets on the hit strobe and clears on a disarm write,
// which takes priority. Holds its level in between, so each armed event
// gives one rising edge.
module evt_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic disarm,
    output logic irq
);

    // Level latch with acknowledge priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (disarm) begin
            irq <= 1'b0;
        end else if (hit) begin
            irq <= 1'b1;
        end
    end

    // R6: a hit without acknowledge raises the line
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !disarm) |=> irq);

    // R6: the line only rises after a hit
    a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    // R7: acknowledge drops the line
    a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !irq);

    // R8: the line stays high until acknowledged
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !disarm) |=> irq);

endmodule

// File: rtl/evt_match_timer.sv
// Top of the match event timer: register file, counter and interrupt
// latch. Everything runs on clk; tick_en is assumed to be already
// synchronous to clk and one cycle wide per sleep-clock tick.
module evt_match_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] match_val;
    logic              run;
    logic              clr_on_match;
    logic              clr_pulse;
    logic              disarm;
    logic              hit;

    evt_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .cnt_val      (cnt_val),
        .bus_rdata    (bus_rdata),
        .match_val    (match_val),
        .run          (run),
        .clr_on_match (clr_on_match),
        .clr_pulse    (clr_pulse),
        .disarm       (disarm)
    );

    evt_timer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .run          (run),
        .clr_on_match (clr_on_match),
        .clr_pulse    (clr_pulse),
        .match_val    (match_val),
        .cnt          (cnt_val),
        .hit          (hit)
    );

    evt_timer_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .disarm (disarm),
        .irq    (irq_out)
    );

    // R1: interrupt is low in the cycle after reset
    a_r1_reset_irq: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

endmodule

// File: tb/evt_match_timer_test.sv
// Scoreboard bench: driver tasks queue expected values, and a monitor
// compares them at the falling edge of the access cycle.
module evt_match_timer_test;

    localparam logic [3:0] A_MATCH = 4'h0;
    localparam logic [3:0] A_COUNT = 4'h4;
    localparam logic [3:0] A_CTRL  = 4'h8;
    localparam logic [3:0] A_CLEAR = 4'hC;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    logic        probe = 1'b0;
    sb_item_t    sb_q[$];
    int          n_run = 0;
    int          n_fail = 0;
    int          n_rise = 0;
    logic        irq_prev = 1'b0;
    bit          done = 1'b0;

    evt_match_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    // Monitor: compare the queued expectation mid-cycle
    always @(negedge clk) begin
        if (probe && sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    // Rising-edge counter on the interrupt line
    always @(posedge clk) begin
        if (irq_out && !irq_prev) n_rise++;
        irq_prev <= irq_out;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; probe = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; probe = 1'b0;
    endtask

    task automatic irqchk(input logic e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
        end
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R1 reset state
        rd(A_MATCH, 32'h0, "R1 match");
        rd(A_COUNT, 32'h0, "R1 count");
        rd(A_CTRL,  32'h0, "R1 ctrl");
        rd(A_CLEAR, 32'h0, "R1 clear");
        irqchk(1'b0, "R1 irq");
        // R2 map, R9 ignored count write and upper ctrl bits
        wr(A_MATCH, 32'h20);
        rd(A_MATCH, 32'h20, "R2 match readback");
        wr(A_COUNT, 32'h55);
        rd(A_COUNT, 32'h0, "R9 count write ignored");
        wr(A_CTRL, 32'hFFFF_FFFC);
        rd(A_CTRL, 32'h0, "R9 ctrl upper bits");
        wr(A_CTRL, 32'h0);
        // R3 counting and holding
        wr(A_CTRL, 32'h1);
        ticks(5);
        rd(A_COUNT, 32'd5, "R3 count after 5 ticks");
        wr(A_CTRL, 32'h0);
        ticks(4);
        rd(A_COUNT, 32'd5, "R3 hold while stopped");
        wr(A_CTRL, 32'h1);
        for (int k = 0; k < 3; k++) begin
            ticks(1);
            idle(1);
        end
        rd(A_COUNT, 32'd8, "R3 sparse ticks");
        // R5 clear register
        wr(A_CLEAR, 32'h1);
        rd(A_COUNT, 32'h0, "R5 clear zeroes count");
        rd(A_CLEAR, 32'h0, "R5 clear reads zero");
        wr(A_CLEAR, 32'h0);
        rd(A_COUNT, 32'h0, "R5 clear write of 0");
        ticks(3);
        wr(A_CLEAR, 32'h0);
        rd(A_COUNT, 32'd3, "R5 zero write keeps count");
        tick = 1'b1;
        wr(A_CLEAR, 32'h1);
        tick = 1'b0;
        rd(A_COUNT, 32'h0, "R5 clear beats tick");
        // R6 match event
        ticks(31);
        rd(A_COUNT, 32'd31, "R6 count before match");
        irqchk(1'b0, "R6 no irq before match");
        ticks(1);
        irqchk(1'b1, "R6 irq at match");
        rd(A_COUNT, 32'd32, "R6 count at match");
        // R8 continues past match, stays high
        ticks(3);
        rd(A_COUNT, 32'd35, "R8 count past match");
        irqchk(1'b1, "R8 irq held");
        // R7 acknowledge
        wr(A_CTRL, 32'h0);
        irqchk(1'b0, "R7 irq dropped");
        ticks(2);
        rd(A_COUNT, 32'd35, "R7 count stopped");
        // R4 clear-on-match with minimum match value
        wr(A_CLEAR, 32'h1);
        wr(A_CLEAR, 32'h0);
        wr(A_MATCH, 32'hF);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, 32'h3, "R4 ctrl readback");
        ticks(14);
        rd(A_COUNT, 32'd14, "R4 count before match");
        irqchk(1'b0, "R6 no irq at 14");
        ticks(1);
        rd(A_COUNT, 32'h0, "R4 reload to zero");
        irqchk(1'b1, "R6 irq at min match");
        ticks(2);
        rd(A_COUNT, 32'd2, "R4 counts on after reload");
        wr(A_CTRL, 32'h0);
        irqchk(1'b0, "R7 ack after reload");
        // R7 disarm wins over a same-cycle match
        wr(A_CLEAR, 32'h1);
        wr(A_CLEAR, 32'h0);
        wr(A_MATCH, 32'h10);
        wr(A_CTRL, 32'h1);
        ticks(15);
        rd(A_COUNT, 32'd15, "R7 setup count");
        tick = 1'b1;
        wr(A_CTRL, 32'h0);
        tick = 1'b0;
        irqchk(1'b0, "R7 disarm beats match");
        rd(A_COUNT, 32'd16, "R7 last tick counted");
        ticks(3);
        rd(A_COUNT, 32'd16, "R7 stopped after disarm");
        // R2 rejected addresses
        wr(4'h1, 32'hAA);
        rd(A_MATCH, 32'h10, "R2 unaligned write ignored");
        rd(4'h9, 32'h0, "R2 unaligned read zero");
        // R8 one rising edge per armed event
        idle(2);
        n_run++;
        if (n_rise != 2) begin
            n_fail++;
            $display("FAIL R8 rising edges: actual %0d expected %0d", n_rise, 2);
        end
        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule